// File: doc/BRIEF.md
# Addressing-Mode Operand Fetch Unit

This unit turns an already decoded operand specifier into a value. It receives a mode code, the current contents of the register the specifier names, an index register value, an address/displacement/immediate field, a scale exponent and the program counter. It works out the effective address and reads the operand through a single-port memory read interface. That interface carries one outstanding request at a time, with a request/valid handshake. The register file is outside the unit, so register contents arrive as inputs. For the auto-modify modes, the unit returns the new register value together with a write enable.

The caller pulses `start` while the unit is idle. The unit registers all of its inputs at that point, so the caller may change them afterwards. It then runs zero, one or two memory reads, depending on the mode. Finally it raises `done` for one cycle and reports the operand, the effective address, the number of memory trips, any write-back value and an error flag. These results stay unchanged until the next operation completes. All address arithmetic is performed modulo 2^AW.

Top module: `amf_fetch_top`

## Requirements
- R1: Mode code 0 (immediate) returns `field` zero-extended, and mode code 1 (register) returns `reg_val`. In both cases `trips` is 0, `eff_addr` is 0 and `mem_req` is never raised.
- R2: Mode code 2 (direct) makes exactly one read at address `field`. `operand` is the data read, `eff_addr` is `field` and `trips` is 1.
- R3: Mode code 3 (memory-indirect) makes two reads. The first read is at `field`. The second read is at the low AW bits of the first data. `operand` is the second data, `eff_addr` is the second address and `trips` is 2.
- R4: Mode code 4 (register-indirect) makes one read at `reg_val`. Mode code 5 (base plus displacement) makes one read at `reg_val + field`, where `field` is a two's-complement displacement. A zero displacement gives the same address as mode 4.
- R5: Mode code 6 (scaled index) makes one read at `reg_val + idx_val * 2^scale`.
- R6: Mode code 7 (PC-relative) makes one read at `pc + field`, where `field` is signed. The target can therefore lie ahead of or behind `pc`.
- R7: Mode code 8 (pre-decrement) makes one read at `reg_val - 1`. It reports `wb_val = reg_val - 1` with `wb_en` high in the `done` cycle only.
- R8: Mode code 9 (post-increment) makes one read at `reg_val`. It reports `wb_val = reg_val + 1` with `wb_en` high in the `done` cycle only.
- R9: Every computed address, including the pointer taken from memory, wraps modulo 2^AW.
- R10: `mem_req` stays high and `mem_addr` stays stable until `mem_rvalid` is seen. Only one read is outstanding at a time.
- R11: `done` lasts one cycle. `operand`, `eff_addr`, `trips`, `err` and `wb_val` hold their values until the next `done`.
- R12: Mode codes 10 to 15 complete with `err` high, `trips` 0, `operand` 0, `wb_en` low and no memory request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Begin an operation (accepted when idle) |
| mode | input | 4 | Addressing mode code |
| reg_val | input | DW | Contents of the named (base) register |
| idx_val | input | DW | Contents of the index register |
| field | input | AW | Immediate, absolute address or signed displacement |
| scale | input | SCW | Element size exponent for scaled index |
| pc | input | AW | Program counter |
| mem_req | output | 1 | Memory read request |
| mem_addr | output | AW | Memory read address |
| mem_rvalid | input | 1 | Read data valid |
| mem_rdata | input | DW | Read data |
| done | output | 1 | One-cycle completion pulse |
| operand | output | DW | Fetched operand |
| eff_addr | output | AW | Effective address of the operand |
| trips | output | 2 | Number of memory reads used |
| wb_en | output | 1 | Register write-back enable (auto-modify modes) |
| wb_val | output | DW | Register write-back value |
| err | output | 1 | Unsupported mode |

## Verification
The bench builds the unit with AW = DW = 4 and SCW = 2, which gives a 16-word address space. With that configuration it can sweep every base and displacement pair, every PC and offset pair, and every base, index and scale combination. Every negative offset and every wrap past the top or bottom of the address space is therefore exercised. The bench memory holds a bijective data pattern, so each pointer chain in the indirect mode is distinct. The memory's response latency rotates between 0 and 2 extra cycles, which exercises the request-hold rule.

// File: rtl/amf_pkg.sv
// Shared definitions for the operand fetch unit: mode codes and sequencer states.
package amf_pkg;
    localparam int MODE_W = 4;

    typedef enum logic [MODE_W-1:0] {
        AM_IMM  = 4'd0,
        AM_REG  = 4'd1,
        AM_DIR  = 4'd2,
        AM_MIND = 4'd3,
        AM_RIND = 4'd4,
        AM_BDSP = 4'd5,
        AM_SCAL = 4'd6,
        AM_PCR  = 4'd7,
        AM_PDEC = 4'd8,
        AM_PINC = 4'd9
    } am_mode_e;

    typedef enum logic [1:0] {
        SQ_IDLE,
        SQ_ISSUE,
        SQ_RD1,
        SQ_RD2
    } sq_state_e;
endpackage

// File: rtl/amf_fields.sv
// Operand specifier capture register.
// Holds the decoded fields from the cycle start is accepted, so the caller
// may change its inputs while the operation is in progress.
// Assumes: accept is high for one cycle per operation.
module amf_fields #(
    parameter int AW  = 16,
    parameter int DW  = 16,
    parameter int SCW = 2
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      accept,
    input  logic [amf_pkg::MODE_W-1:0] mode_i,
    input  logic [DW-1:0]             reg_i,
    input  logic [DW-1:0]             idx_i,
    input  logic [AW-1:0]             field_i,
    input  logic [SCW-1:0]            scale_i,
    input  logic [AW-1:0]             pc_i,
    output logic [amf_pkg::MODE_W-1:0] mode_q,
    output logic [DW-1:0]             reg_q,
    output logic [DW-1:0]             idx_q,
    output logic [AW-1:0]             field_q,
    output logic [SCW-1:0]            scale_q,
    output logic [AW-1:0]             pc_q
);
    // Capture the specifier on acceptance, clear on reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode_q  <= '0;
            reg_q   <= '0;
            idx_q   <= '0;
            field_q <= '0;
            scale_q <= '0;
            pc_q    <= '0;
        end else if (accept) begin
            mode_q  <= mode_i;
            reg_q   <= reg_i;
            idx_q   <= idx_i;
            field_q <= field_i;
            scale_q <= scale_i;
            pc_q    <= pc_i;
        end
    end
endmodule

// File: rtl/amf_ea_calc.sv
// Effective address and mode classification.
// Purely combinational. For every mode it gives the first read address,
// the number of reads, the auto-modify write-back value and the value of a
// mode that needs no read. All address sums are AW bits wide, so they wrap
// modulo 2^AW, and a signed field added in AW bits gives a backward offset.
// Assumes: DW >= AW (a register or memory word can hold an address).
module amf_ea_calc #(
    parameter int AW  = 16,
    parameter int DW  = 16,
    parameter int SCW = 2
) (
    input  logic [amf_pkg::MODE_W-1:0] mode_q,
    input  logic [DW-1:0]             reg_q,
    input  logic [DW-1:0]             idx_q,
    input  logic [AW-1:0]             field_q,
    input  logic [SCW-1:0]            scale_q,
    input  logic [AW-1:0]             pc_q,
    output logic [AW-1:0]             ea,
    output logic [1:0]                n_trips,
    output logic                      auto_mod,
    output logic                      illegal,
    output logic [DW-1:0]             wb_calc,
    output logic [DW-1:0]             direct_val
);
    import amf_pkg::*;

    logic [AW-1:0] base_a;
    logic [AW-1:0] idx_a;

    assign base_a = reg_q[AW-1:0];
    assign idx_a  = idx_q[AW-1:0];

    // Decode the mode into address, trip count and write-back.
    always_comb begin
        ea         = '0;
        n_trips    = 2'd0;
        auto_mod   = 1'b0;
        illegal    = 1'b0;
        wb_calc    = '0;
        direct_val = '0;
        case (am_mode_e'(mode_q))
            AM_IMM:  direct_val = DW'(field_q);
            AM_REG:  direct_val = reg_q;
            AM_DIR: begin
                ea      = field_q;
                n_trips = 2'd1;
            end
            AM_MIND: begin
                ea      = field_q;
                n_trips = 2'd2;
            end
            AM_RIND: begin
                ea      = base_a;
                n_trips = 2'd1;
            end
            AM_BDSP: begin
                ea      = base_a + field_q;
                n_trips = 2'd1;
            end
            AM_SCAL: begin
                ea      = base_a + (idx_a << scale_q);
                n_trips = 2'd1;
            end
            AM_PCR: begin
                ea      = pc_q + field_q;
                n_trips = 2'd1;
            end
            AM_PDEC: begin
                ea       = base_a - AW'(1);
                n_trips  = 2'd1;
                auto_mod = 1'b1;
                wb_calc  = reg_q - DW'(1);
            end
            AM_PINC: begin
                ea       = base_a;
                n_trips  = 2'd1;
                auto_mod = 1'b1;
                wb_calc  = reg_q + DW'(1);
            end
            default: illegal = 1'b1;
        endcase
    end
endmodule

// File: rtl/amf_seq.sv
// Memory trip sequencer.
// Walks IDLE -> ISSUE -> RD1 [-> RD2] -> IDLE. It holds the read request
// until valid arrives, chains a second read for the indirect mode, and
// registers the results together with a one-cycle done pulse.
// Assumes: the memory returns exactly one valid per request.
module amf_seq #(
    parameter int AW = 16,
    parameter int DW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic [AW-1:0] ea,
    input  logic [1:0]    n_trips,
    input  logic          auto_mod,
    input  logic          illegal,
    input  logic [DW-1:0] wb_calc,
    input  logic [DW-1:0] direct_val,
    input  logic          mem_rvalid,
    input  logic [DW-1:0] mem_rdata,
    output logic          accept,
    output logic          mem_req,
    output logic [AW-1:0] mem_addr,
    output logic          done,
    output logic [DW-1:0] operand,
    output logic [AW-1:0] eff_addr,
    output logic [1:0]    trips,
    output logic          wb_en,
    output logic [DW-1:0] wb_val,
    output logic          err
);
    import amf_pkg::*;

    sq_state_e     state;
    logic [AW-1:0] ptr_q;

    // Request is active only in the read states; the second read uses the pointer.
    assign accept   = start && (state == SQ_IDLE);
    assign mem_req  = (state == SQ_RD1) || (state == SQ_RD2);
    assign mem_addr = (state == SQ_RD2) ? ptr_q : ea;

    // State progression and result registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state    <= SQ_IDLE;
            ptr_q    <= '0;
            done     <= 1'b0;
            operand  <= '0;
            eff_addr <= '0;
            trips    <= 2'd0;
            wb_en    <= 1'b0;
            wb_val   <= '0;
            err      <= 1'b0;
        end else begin
            done  <= 1'b0;
            wb_en <= 1'b0;
            case (state)
                SQ_IDLE: if (start) state <= SQ_ISSUE;
                SQ_ISSUE: begin
                    if (illegal || n_trips == 2'd0) begin
                        done     <= 1'b1;
                        operand  <= illegal ? '0 : direct_val;
                        eff_addr <= '0;
                        trips    <= 2'd0;
                        wb_val   <= '0;
                        err      <= illegal;
                        state    <= SQ_IDLE;
                    end else begin
                        state <= SQ_RD1;
                    end
                end
                SQ_RD1: if (mem_rvalid) begin
                    if (n_trips == 2'd2) begin
                        ptr_q <= mem_rdata[AW-1:0];
                        state <= SQ_RD2;
                    end else begin
                        done     <= 1'b1;
                        operand  <= mem_rdata;
                        eff_addr <= ea;
                        trips    <= 2'd1;
                        wb_en    <= auto_mod;
                        wb_val   <= auto_mod ? wb_calc : '0;
                        err      <= 1'b0;
                        state    <= SQ_IDLE;
                    end
                end
                SQ_RD2: if (mem_rvalid) begin
                    done     <= 1'b1;
                    operand  <= mem_rdata;
                    eff_addr <= ptr_q;
                    trips    <= 2'd2;
                    wb_val   <= '0;
                    err      <= 1'b0;
                    state    <= SQ_IDLE;
                end
                default: state <= SQ_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/amf_fetch_top.sv
// Addressing-mode operand fetch unit, top level.
// Captures the operand specifier, computes the effective address and runs
// the memory reads the mode needs, then reports the operand, the address,
// the trip count and any auto-modify write-back value.
// Assumes: DW >= AW; register contents come from an external register file.
module amf_fetch_top #(
    parameter int AW  = 16,
    parameter int DW  = 16,
    parameter int SCW = 2
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           start,
    input  logic [3:0]     mode,
    input  logic [DW-1:0]  reg_val,
    input  logic [DW-1:0]  idx_val,
    input  logic [AW-1:0]  field,
    input  logic [SCW-1:0] scale,
    input  logic [AW-1:0]  pc,
    output logic           mem_req,
    output logic [AW-1:0]  mem_addr,
    input  logic           mem_rvalid,
    input  logic [DW-1:0]  mem_rdata,
    output logic           done,
    output logic [DW-1:0]  operand,
    output logic [AW-1:0]  eff_addr,
    output logic [1:0]     trips,
    output logic           wb_en,
    output logic [DW-1:0]  wb_val,
    output logic           err
);
    logic [3:0]     mode_q;
    logic [DW-1:0]  reg_q;
    logic [DW-1:0]  idx_q;
    logic [AW-1:0]  field_q;
    logic [SCW-1:0] scale_q;
    logic [AW-1:0]  pc_q;
    logic           accept;
    logic [AW-1:0]  ea;
    logic [1:0]     n_trips;
    logic           auto_mod;
    logic           illegal;
    logic [DW-1:0]  wb_calc;
    logic [DW-1:0]  direct_val;

    amf_fields #(.AW(AW), .DW(DW), .SCW(SCW)) u_fields (
        .clk(clk), .rst_n(rst_n), .accept(accept),
        .mode_i(mode), .reg_i(reg_val), .idx_i(idx_val),
        .field_i(field), .scale_i(scale), .pc_i(pc),
        .mode_q(mode_q), .reg_q(reg_q), .idx_q(idx_q),
        .field_q(field_q), .scale_q(scale_q), .pc_q(pc_q)
    );

    amf_ea_calc #(.AW(AW), .DW(DW), .SCW(SCW)) u_calc (
        .mode_q(mode_q), .reg_q(reg_q), .idx_q(idx_q),
        .field_q(field_q), .scale_q(scale_q), .pc_q(pc_q),
        .ea(ea), .n_trips(n_trips), .auto_mod(auto_mod),
        .illegal(illegal), .wb_calc(wb_calc), .direct_val(direct_val)
    );

    amf_seq #(.AW(AW), .DW(DW)) u_seq (
        .clk(clk), .rst_n(rst_n), .start(start),
        .ea(ea), .n_trips(n_trips), .auto_mod(auto_mod),
        .illegal(illegal), .wb_calc(wb_calc), .direct_val(direct_val),
        .mem_rvalid(mem_rvalid), .mem_rdata(mem_rdata),
        .accept(accept), .mem_req(mem_req), .mem_addr(mem_addr),
        .done(done), .operand(operand), .eff_addr(eff_addr),
        .trips(trips), .wb_en(wb_en), .wb_val(wb_val), .err(err)
    );
endmodule

// File: rtl/amf_fetch_chk.sv
// Protocol checker for amf_fetch_top, attached by bind.
// Checks the port-level rules on the handshake, the done pulse and the results.
module amf_fetch_chk #(
    parameter int AW = 16,
    parameter int DW = 16
) (
    input logic          clk,
    input logic          rst_n,
    input logic          mem_req,
    input logic [AW-1:0] mem_addr,
    input logic          mem_rvalid,
    input logic          done,
    input logic [DW-1:0] operand,
    input logic [AW-1:0] eff_addr,
    input logic [1:0]    trips,
    input logic          wb_en,
    input logic          err
);
    // R1: a zero-trip completion is not preceded by a request
    p_zero_trip_no_req_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (done && trips == 2'd0) |-> !$past(mem_req));

    // R3: trip count never exceeds two
    p_trip_bound_r3: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (trips != 2'd3));

    // R7: write-back enable only appears with done
    p_wb_with_done_r7: assert property (@(posedge clk) disable iff (!rst_n)
        wb_en |-> done);

    // R10: request and address held until valid
    p_req_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_rvalid) |=> (mem_req && $stable(mem_addr)));

    // R11: done is a single-cycle pulse
    p_done_pulse_r11: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R11: results hold between completions
    p_out_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !done |-> ($stable(operand) && $stable(eff_addr) && $stable(trips) && $stable(err)));

    // R12: an error completion uses no trips and no write-back
    p_err_clean_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (done && err) |-> (trips == 2'd0 && !wb_en));
endmodule

bind amf_fetch_top amf_fetch_chk #(.AW(AW), .DW(DW)) u_chk (
    .clk(clk), .rst_n(rst_n), .mem_req(mem_req), .mem_addr(mem_addr),
    .mem_rvalid(mem_rvalid), .done(done), .operand(operand),
    .eff_addr(eff_addr), .trips(trips), .wb_en(wb_en), .err(err)
);

// File: tb/tb_amf_fetch_top.sv
// Sweeping bench for amf_fetch_top in a 4-bit address space.
module tb_amf_fetch_top;
    localparam int AW = 4;
    localparam int DW = 4;
    localparam int SCW = 2;
    localparam int CLK_PERIOD = 10;
    localparam int MSK = (1 << AW) - 1;

    logic           clk = 1'b0;
    logic           rst_n = 1'b0;
    logic           start = 1'b0;
    logic [3:0]     mode = '0;
    logic [DW-1:0]  reg_val = '0;
    logic [DW-1:0]  idx_val = '0;
    logic [AW-1:0]  field = '0;
    logic [SCW-1:0] scale = '0;
    logic [AW-1:0]  pc = '0;
    logic           mem_req;
    logic [AW-1:0]  mem_addr;
    logic           mem_rvalid;
    logic [DW-1:0]  mem_rdata;
    logic           done;
    logic [DW-1:0]  operand;
    logic [AW-1:0]  eff_addr;
    logic [1:0]     trips;
    logic           wb_en;
    logic [DW-1:0]  wb_val;
    logic           err;

    int checks = 0;
    int errors = 0;
    int cycles = 0;
    int rd_cnt = 0;
    int rd_mark = 0;
    int first_addr = 0;
    int lat = 0;
    int wait_cnt = 0;

    amf_fetch_top #(.AW(AW), .DW(DW), .SCW(SCW)) dut (.*);

    always #(CLK_PERIOD/2) clk = ~clk;

    // Memory contents: a bijection of the address.
    function automatic int memf(input int a);
        return ((a & MSK) * 5 + 3) & MSK;
    endfunction

    // Memory model with a selectable response latency.
    always @(posedge clk) begin
        if (!rst_n) begin
            mem_rvalid <= 1'b0;
            mem_rdata  <= '0;
            wait_cnt   <= 0;
        end else begin
            mem_rvalid <= 1'b0;
            if (mem_req && !mem_rvalid) begin
                if (wait_cnt >= lat) begin
                    mem_rvalid <= 1'b1;
                    mem_rdata  <= DW'(memf(int'(mem_addr)));
                    wait_cnt   <= 0;
                    if (rd_cnt == rd_mark) first_addr <= int'(mem_addr);
                    rd_cnt <= rd_cnt + 1;
                end else begin
                    wait_cnt <= wait_cnt + 1;
                end
            end
        end
    end

    // Watchdog.
    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles > 150000) begin
            errors = errors + 1;
            checks = checks + 1;
            $display("FAIL watchdog: act=%0d exp=<150000 cycles", cycles);
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    task automatic chk(input string tag, input int act, input int exp);
        checks = checks + 1;
        if (act != exp) begin
            errors = errors + 1;
            $display("FAIL %s: act=%0d exp=%0d", tag, act, exp);
        end
    endtask

    task automatic run_op(input int m, input int b, input int x, input int d,
                          input int s, input int p, input int e_op, input int e_ea,
                          input int e_tr, input int e_wb, input int e_wbv,
                          input int e_err, input string tag);
        int n;
        int got_op;
        @(negedge clk);
        mode = 4'(m); reg_val = DW'(b); idx_val = DW'(x);
        field = AW'(d); scale = SCW'(s); pc = AW'(p);
        rd_mark = rd_cnt;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        // scramble inputs to show they were captured
        reg_val = ~reg_val; idx_val = ~idx_val; field = ~field; pc = ~pc;
        n = 0;
        while (!done && n < 30) begin
            @(negedge clk);
            n++;
        end
        chk({tag, " done seen"}, int'(done), 1);
        chk({tag, " operand"}, int'(operand), e_op);
        chk({tag, " eff_addr"}, int'(eff_addr), e_ea);
        chk({tag, " trips"}, int'(trips), e_tr);
        chk({tag, " reads issued"}, rd_cnt - rd_mark, e_tr);
        if (e_tr == 2) chk({tag, " first read addr"}, first_addr, d & MSK);
        chk({tag, " wb_en"}, int'(wb_en), e_wb);
        if (e_wb == 1) chk({tag, " wb_val"}, int'(wb_val), e_wbv);
        chk({tag, " err"}, int'(err), e_err);
        got_op = int'(operand);
        @(negedge clk);
        chk("R11 done one cycle", int'(done), 0);
        chk("R11 operand held", int'(operand), got_op);
        lat = (lat + 1) % 3;
    endtask

    initial begin
        repeat (4) @(negedge clk);
        chk("reset done", int'(done), 0);
        chk("reset mem_req", int'(mem_req), 0);
        chk("reset operand", int'(operand), 0);
        chk("reset err", int'(err), 0);
        rst_n = 1'b1;

        for (int v = 0; v <= MSK; v++) begin
            // R1 immediate and register
            run_op(0, 9, 0, v, 0, 0, v, 0, 0, 0, 0, 0, "R1 imm");
            run_op(1, v, 0, 5, 0, 0, v, 0, 0, 0, 0, 0, "R1 reg");
            // R2 direct
            run_op(2, 0, 0, v, 0, 0, memf(v), v, 1, 0, 0, 0, "R2 direct");
            // R3 indirect, pointer wrap R9
            run_op(3, 0, 0, v, 0, 0, memf(memf(v)), memf(v), 2, 0, 0, 0, "R3 indirect");
            // R4 register-indirect
            run_op(4, v, 0, 0, 0, 0, memf(v), v, 1, 0, 0, 0, "R4 reg-ind");
            // R7 pre-decrement with wrap R9
            run_op(8, v, 0, 0, 0, 0, memf((v - 1) & MSK), (v - 1) & MSK, 1, 1,
                   (v - 1) & MSK, 0, "R7 R9 predec");
            // R8 post-increment with wrap R9
            run_op(9, v, 0, 0, 0, 0, memf(v), v, 1, 1, (v + 1) & MSK, 0, "R8 R9 postinc");
        end

        for (int b = 0; b <= MSK; b++) begin
            for (int d = 0; d <= MSK; d++) begin
                // R4 base plus signed displacement, zero displacement included
                run_op(5, b, 0, d, 0, 0, memf((b + d) & MSK), (b + d) & MSK, 1, 0, 0, 0,
                       "R4 R9 base+disp");
                // R6 PC-relative forward and backward
                run_op(7, 0, 0, d, 0, b, memf((b + d) & MSK), (b + d) & MSK, 1, 0, 0, 0,
                       "R6 R9 pc-rel");
            end
        end

        for (int b = 0; b <= MSK; b++) begin
            for (int x = 0; x <= MSK; x++) begin
                for (int s = 0; s < (1 << SCW); s++) begin
                    // R5 scaled index
                    run_op(6, b, x, 0, s, 0, memf((b + x * (1 << s)) & MSK),
                           (b + x * (1 << s)) & MSK, 1, 0, 0, 0, "R5 R9 scaled");
                end
            end
        end

        for (int m = 10; m <= 15; m++) begin
            // R12 unsupported codes
            run_op(m, 7, 3, 5, 1, 2, 0, 0, 0, 0, 0, 1, "R12 bad mode");
        end

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule